// File: doc/BRIEF.md
# Switch Input Buffer with Selectable Switching Discipline

This block sits at one input port of a packet switch. It stores incoming flits in a small ring buffer and decides when each packet may start leaving towards the downstream hop. A two-bit mode input selects one of three disciplines: whole-packet buffering before any departure (store-and-forward), early departure with packet-granular flow control (virtual cut-through), or early departure with flit-granular flow control (wormhole). Downstream space is tracked by a credit counter that loses one credit per flit sent and gains one per credit pulse returned.

On the upstream side, the block raises a stall signal when it cannot take the flit that is offered. In the two packet-granular modes, a packet head is only admitted when the buffer has room for the whole packet, as announced in the head's length field. In wormhole mode, admission is flit by flit, so a packet longer than the buffer is spread over several hops when it blocks.

Two small state machines make up the control. The admission machine has states ADM_IDLE (waiting for a head) and ADM_PKT (inside a packet). It moves ADM_IDLE→ADM_PKT on an accepted head of a multi-flit packet and ADM_PKT→ADM_IDLE on an accepted tail. The departure machine has states SCH_IDLE (no packet on the output) and SCH_FWD (output reserved for the packet in flight). It moves SCH_IDLE→SCH_FWD when a multi-flit head departs and SCH_FWD→SCH_IDLE when the tail departs. A single-flit packet departs from SCH_IDLE and leaves the machine in SCH_IDLE.

Top module: `flit_inbuf`

## Requirements
- R1: After reset the buffer is empty, `out_valid_o` and `in_stall_o` are low, and the credit count equals `CRD_INIT`.
- R2: Flit kinds are coded 0 body, 1 head, 2 tail and 3 single-flit packet; codes 1 and 3 open a packet and codes 2 and 3 close it. The kind of each flit is reproduced on `out_kind_o`.
- R3: In mode 1 (virtual cut-through), a head may depart before the remaining flits of its packet have arrived.
- R4: In modes 0 and 1, a head departs only when the credit count is at least the packet length held in the low `LEN_W` bits of the head's data.
- R5: In modes 0 and 1, an offered head is stalled while the free buffer slots are fewer than its length field.
- R6: A flit offered while `in_stall_o` is high is not stored and never appears on the output.
- R7: Flits leave in arrival order, and once a head has left, the remaining stored flits of that packet leave on consecutive cycles while credits allow.
- R8: In mode 2 (wormhole), a head departs with a single credit whatever its length field, and each later flit needs one credit.
- R9: In every mode, `in_stall_o` is high when all `DEPTH` slots are occupied.
- R10: No flit leaves while the credit count is zero. The count drops by one per flit sent and rises by one per `crd_ret_i` pulse.
- R11: In mode 0 (store-and-forward), no flit of a packet leaves until its closing flit is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Discipline: 0 store-and-forward, 1 virtual cut-through, 2 wormhole; change only while empty |
| in_valid_i | input | 1 | Upstream offers a flit |
| in_kind_i | input | 2 | Kind of the offered flit |
| in_data_i | input | DATA_W | Flit payload; on a head the low LEN_W bits hold the packet length |
| in_stall_o | output | 1 | Back-pressure; the offered flit is not taken while high |
| out_valid_o | output | 1 | A flit leaves at the next rising edge |
| out_kind_o | output | 2 | Kind of the departing flit |
| out_data_o | output | DATA_W | Payload of the departing flit |
| crd_ret_i | input | 1 | One downstream credit returned per cycle high |

## Verification
The hardest condition to reach is a head that sits at the front of the buffer while other flits are already stored behind it, because the credits are too few or the packet is incomplete. The bench withholds credit pulses to drain the count to zero, so that packets pile up. It then offers heads whose length field exceeds the free space, or a flit into a full buffer, and checks both the stall and the absence of that flit on the output. A final wormhole head with a large length field and exactly one returned credit shows the difference between per-flit and per-packet departure rules.

// File: rtl/flit_inbuf_pkg.sv
package flit_inbuf_pkg;

    typedef enum logic [1:0] {
        K_BODY = 2'd0,
        K_HEAD = 2'd1,
        K_TAIL = 2'd2,
        K_SOLO = 2'd3
    } flit_kind_e;

    typedef enum logic [1:0] {
        SW_SAF  = 2'd0,
        SW_VCT  = 2'd1,
        SW_WH   = 2'd2,
        SW_RSVD = 2'd3
    } sw_mode_e;

    // A flit that starts a packet
    function automatic logic kind_opens(input logic [1:0] k);
        return (k == K_HEAD) || (k == K_SOLO);
    endfunction

    // A flit that ends a packet
    function automatic logic kind_closes(input logic [1:0] k);
        return (k == K_TAIL) || (k == K_SOLO);
    endfunction

    // Packet-granular admission applies in these modes
    function automatic logic mode_whole_pkt(input sw_mode_e m);
        return (m == SW_SAF) || (m == SW_VCT);
    endfunction

endpackage

// File: rtl/ibuf_store.sv
module ibuf_store
    import flit_inbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [1:0]        rd_kind,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  free,
    output logic [CNT_W-1:0]  ends_held
);

    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [1:0]        slot_kind [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  fill;
    logic              wr_ends;
    logic              rd_ends;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (fill == '0);
    assign full    = (fill == CNT_W'(DEPTH));
    assign free    = CNT_W'(DEPTH) - fill;
    assign rd_kind = slot_kind[rd_ptr];
    assign rd_data = slot_data[rd_ptr];
    assign wr_ends = wr_en && kind_closes(wr_kind);
    assign rd_ends = rd_en && kind_closes(rd_kind);

    // One write port per slot
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == PTR_W'(s))) begin
                slot_data[s] <= wr_data;
                slot_kind[s] <= wr_kind;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            fill      <= '0;
            ends_held <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_next(wr_ptr);
            if (rd_en) rd_ptr <= ptr_next(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
            unique case ({wr_ends, rd_ends})
                2'b10:   ends_held <= ends_held + 1'b1;
                2'b01:   ends_held <= ends_held - 1'b1;
                default: ends_held <= ends_held;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty); // R7
    AST_ENDS_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ends_held <= fill); // R11

endmodule

// File: rtl/ibuf_credit.sv
module ibuf_credit #(
    parameter int CRD_INIT = 4,
    localparam int CRD_W   = $clog2(CRD_INIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give,
    output logic [CRD_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CRD_W'(CRD_INIT);
        end else begin
            unique case ({take, give})
                2'b10:   count <= count - 1'b1;
                2'b01:   count <= count + 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_CRD_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (count != '0)); // R10
    AST_CRD_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (give && !take) |-> (count < CRD_W'(CRD_INIT))); // R10

endmodule

// File: rtl/ibuf_admit.sv
module ibuf_admit
    import flit_inbuf_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int MAX_PKT = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sw_mode_e         mode,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [LEN_W-1:0] in_len,
    input  logic [CNT_W-1:0] free,
    input  logic             full,
    output logic             stall,
    output logic             accept
);

    typedef enum logic {
        ADM_IDLE = 1'b0,
        ADM_PKT  = 1'b1
    } adm_state_e;

    adm_state_e state_q;
    adm_state_e state_d;
    logic       short_room;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ADM_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ADM_IDLE: if (accept && kind_opens(in_kind) && !kind_closes(in_kind))
                          state_d = ADM_PKT;
            ADM_PKT:  if (accept && kind_closes(in_kind))
                          state_d = ADM_IDLE;
            default:  state_d = ADM_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        short_room = mode_whole_pkt(mode) && (state_q == ADM_IDLE)
                     && kind_opens(in_kind) && (int'(free) < int'(in_len));
        stall  = full || (in_valid && short_room);
        accept = in_valid && !stall;
    end

    AST_ADMIT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_whole_pkt(mode) && (state_q == ADM_IDLE) && kind_opens(in_kind))
        |-> (int'(free) >= int'(in_len))); // R5
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !accept); // R9

endmodule

// File: rtl/ibuf_sched.sv
module ibuf_sched
    import flit_inbuf_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int CRD_INIT = 4,
    parameter int MAX_PKT  = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int CRD_W   = $clog2(CRD_INIT + 1),
    localparam int LEN_W   = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sw_mode_e         mode,
    input  logic             empty,
    input  logic [1:0]       head_kind,
    input  logic [LEN_W-1:0] head_len,
    input  logic [CNT_W-1:0] ends_held,
    input  logic [CRD_W-1:0] credits,
    output logic             send
);

    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_FWD  = 1'b1
    } sch_state_e;

    sch_state_e state_q;
    sch_state_e state_d;
    logic       have_crd;
    logic       crd_covers;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCH_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_IDLE: if (send && (head_kind == K_HEAD)) state_d = SCH_FWD;
            SCH_FWD:  if (send && kind_closes(head_kind)) state_d = SCH_IDLE;
            default:  state_d = SCH_IDLE;
        endcase
    end

    // Outputs: departure rule per discipline
    always_comb begin
        have_crd   = (credits != '0);
        crd_covers = have_crd && (int'(credits) >= int'(head_len));
        send       = 1'b0;
        unique case (state_q)
            SCH_IDLE: begin
                if (!empty) begin
                    unique case (mode)
                        SW_SAF:  send = crd_covers && (ends_held != '0);
                        SW_VCT:  send = crd_covers;
                        default: send = have_crd;
                    endcase
                end
            end
            SCH_FWD:  send = !empty && have_crd;
            default:  send = 1'b0;
        endcase
    end

    AST_FWD_NO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SCH_FWD) && send) |-> !kind_opens(head_kind)); // R7
    AST_IDLE_SEES_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SCH_IDLE) && send) |-> kind_opens(head_kind)); // R2
    AST_SAF_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == SW_SAF) && send) |-> (ends_held != '0)); // R11
    AST_VCT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == SW_VCT) && (state_q == SCH_IDLE) && send)
        |-> (int'(credits) >= int'(head_len))); // R4

endmodule

// File: rtl/flit_inbuf.sv
module flit_inbuf
    import flit_inbuf_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 4,
    parameter int CRD_INIT = 4,
    parameter int MAX_PKT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              in_valid_i,
    input  logic [1:0]        in_kind_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_stall_o,
    output logic              out_valid_o,
    output logic [1:0]        out_kind_o,
    output logic [DATA_W-1:0] out_data_o,
    input  logic              crd_ret_i
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CRD_W = $clog2(CRD_INIT + 1);
    localparam int LEN_W = $clog2(MAX_PKT + 1);

    sw_mode_e          mode;
    logic              accept;
    logic              send;
    logic              empty;
    logic              full;
    logic [CNT_W-1:0]  free;
    logic [CNT_W-1:0]  ends_held;
    logic [CRD_W-1:0]  credits;
    logic [1:0]        head_kind;
    logic [DATA_W-1:0] head_data;

    assign mode = sw_mode_e'(mode_i);

    ibuf_admit #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_admit (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .in_valid (in_valid_i),
        .in_kind  (in_kind_i),
        .in_len   (in_data_i[LEN_W-1:0]),
        .free     (free),
        .full     (full),
        .stall    (in_stall_o),
        .accept   (accept)
    );

    ibuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_kind   (in_kind_i),
        .wr_data   (in_data_i),
        .rd_en     (send),
        .rd_kind   (head_kind),
        .rd_data   (head_data),
        .empty     (empty),
        .full      (full),
        .free      (free),
        .ends_held (ends_held)
    );

    ibuf_credit #(.CRD_INIT(CRD_INIT)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (send),
        .give  (crd_ret_i),
        .count (credits)
    );

    ibuf_sched #(.DEPTH(DEPTH), .CRD_INIT(CRD_INIT), .MAX_PKT(MAX_PKT)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .empty     (empty),
        .head_kind (head_kind),
        .head_len  (head_data[LEN_W-1:0]),
        .ends_held (ends_held),
        .credits   (credits),
        .send      (send)
    );

    assign out_valid_o = send;
    assign out_kind_o  = head_kind;
    assign out_data_o  = head_data;

    AST_MODE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_i) |-> $past(empty)); // R1
    AST_NO_SEND_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        (credits == '0) |-> !out_valid_o); // R10

endmodule

// File: tb/test_flit_inbuf.sv
module test_flit_inbuf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       iv = 1'b0;
    logic [1:0] ik = 2'd0;
    logic [7:0] id = 8'd0;
    logic       cr = 1'b0;
    logic       stall;
    logic       ov;
    logic [1:0] ok;
    logic [7:0] od;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_out = 0;
    bit done = 1'b0;
    logic last_stall;
    logic [7:0] log_d [64];
    logic [1:0] log_k [64];
    int         log_c [64];

    flit_inbuf #(.DATA_W(8), .DEPTH(4), .CRD_INIT(4), .MAX_PKT(4)) i_flit_inbuf (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .in_valid_i(iv), .in_kind_i(ik), .in_data_i(id), .in_stall_o(stall),
        .out_valid_o(ov), .out_kind_o(ok), .out_data_o(od), .crd_ret_i(cr)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    // Each falling edge with valid high marks one departing flit
    always @(negedge clk) begin
        if (rst_n && ov && n_out < 64) begin
            log_d[n_out] = od;
            log_k[n_out] = ok;
            log_c[n_out] = cyc;
            n_out = n_out + 1;
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] k, input logic [7:0] d);
        @(negedge clk);
        iv = 1'b1; ik = k; id = d;
        #1 last_stall = stall;
        @(posedge clk);
        #1 iv = 1'b0;
    endtask

    task automatic ret(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cr = 1'b1;
            @(posedge clk);
            #1 cr = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);
        check(ov == 1'b0, "R1 out_valid after reset", ov, 0);
        check(stall == 1'b0, "R1 stall after reset", stall, 0);

        // Store-and-forward: nothing leaves before the tail
        put(2'd1, 8'h13);
        idle(2);
        check(n_out == 0, "R11 head held", n_out, 0);
        put(2'd0, 8'hA1);
        idle(2);
        check(n_out == 0, "R11 body held", n_out, 0);
        put(2'd2, 8'hA2);
        idle(4);
        check(n_out == 3, "R11 packet released", n_out, 3);
        check(log_d[0] == 8'h13 && log_d[1] == 8'hA1 && log_d[2] == 8'hA2,
              "R7 order saf", log_d[2], 8'hA2);
        check(log_c[2] - log_c[0] == 2, "R7 back-to-back", log_c[2] - log_c[0], 2);
        check(log_k[0] == 2'd1 && log_k[1] == 2'd0 && log_k[2] == 2'd2,
              "R2 kinds", log_k[2], 2);
        ret(3);

        // Virtual cut-through: head leaves early
        mode = 2'd1;
        put(2'd1, 8'h23);
        idle(1);
        check(n_out == 4, "R3 head before body", n_out, 4);
        put(2'd0, 8'hB1);
        put(2'd2, 8'hB2);
        idle(3);
        check(n_out == 6 && log_d[5] == 8'hB2, "R3 packet done", n_out, 6);

        // Credits 1, length 2: head waits
        put(2'd1, 8'h32);
        idle(3);
        check(n_out == 6, "R4 head waits for credits", n_out, 6);
        ret(1);
        idle(2);
        check(n_out == 7 && log_d[6] == 8'h32, "R4 head goes", n_out, 7);
        put(2'd2, 8'hC1);
        idle(2);
        check(n_out == 8, "R10 tail with last credit", n_out, 8);

        // Credits 0: packet stuck, then admission shortfall
        put(2'd1, 8'h42);
        check(last_stall == 1'b0, "R5 room for len2", last_stall, 0);
        put(2'd2, 8'hD1);
        idle(2);
        check(n_out == 8, "R10 zero credits", n_out, 8);
        put(2'd1, 8'h53);
        check(last_stall == 1'b1, "R5 len3 head, 2 free", last_stall, 1);
        ret(4);
        idle(3);
        check(n_out == 10 && log_d[8] == 8'h42 && log_d[9] == 8'hD1,
              "R7 stuck packet drains", n_out, 10);
        idle(3);
        check(n_out == 10, "R6 stalled head dropped", n_out, 10);
        ret(2);

        // Wormhole: packet longer than the buffer
        mode = 2'd2;
        put(2'd1, 8'h86);
        check(last_stall == 1'b0, "R8 head taken", last_stall, 0);
        for (int i = 1; i <= 4; i++) put(2'd0, 8'hE0 + 8'(i));
        put(2'd2, 8'hE5);
        check(last_stall == 1'b0, "R8 tail taken", last_stall, 0);
        idle(2);
        check(n_out == 14, "R8 four credits four flits", n_out, 14);
        ret(2);
        idle(2);
        check(n_out == 16 && log_d[15] == 8'hE5, "R8 rest after credits", n_out, 16);
        for (int i = 0; i < 6; i++)
            check(log_d[10 + i] == ((i == 0) ? 8'h86 : 8'hE0 + 8'(i)),
                  "R7 order wormhole", log_d[10 + i], (i == 0) ? 8'h86 : 8'hE0 + i);

        // Fill to full with zero credits
        put(2'd1, 8'h84);
        for (int i = 1; i <= 3; i++) put(2'd0, 8'hF0 + 8'(i));
        put(2'd2, 8'hF4);
        check(last_stall == 1'b1, "R9 full stalls", last_stall, 1);
        ret(1);
        idle(2);
        check(n_out == 17 && log_d[16] == 8'h84, "R8 head on one credit", n_out, 17);
        put(2'd2, 8'hF4);
        check(last_stall == 1'b0, "R9 room again", last_stall, 0);
        ret(4);
        idle(2);
        check(n_out == 21 && log_d[20] == 8'hF4, "R6 tail once only", n_out, 21);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule